// File: doc/BRIEF.md
# Phase/Frequency Comparator with Steering

This block compares a reference square wave, taken from a divided crystal oscillator, against a squared feedback pulse train from a speed sensor. It drives a pump-up and a pump-down enable that feed an external loop filter. Both inputs are oversampled by a fast system clock. Each input passes through its own synchronizer and edge detector.

When the two rates agree, the block works as a phase comparator. The up enable is high from a reference event until the next feedback event. The down enable is high from a feedback event until the next reference event. Two events from the same input with no event from the other input between them mean the rates differ. The block then latches full drive toward the faster input. It gives up that steering only after the inputs alternate again. A lock flag reports a run of alternating events with no rate error. A configuration input, captured during reset, makes falling feedback and reference transitions count as events as well, which doubles the event rate.

Top module: `phase_freq_steer`

## Requirements
- R1: A level change on an input that is present at one rising clock edge shows at the outputs on the second rising edge after that one. The outputs do not change in any cycle without an event.
- R2: In single-edge mode (dual_edge_cfg low at reset), only a low-to-high input transition is an event. Falling transitions leave all outputs unchanged.
- R3: In dual-edge mode (dual_edge_cfg high at reset), both transitions of either input are events.
- R4: dual_edge_cfg is captured only while rst is high. Changing it after reset has no effect on event detection.
- R5: In phase mode, a reference-only event sets pump_up=1 and pump_dn=0, and this holds until the next event.
- R6: In phase mode, a feedback-only event sets pump_dn=1 and pump_up=0, and this holds until the next event.
- R7: In phase mode, reference and feedback events in the same cycle set both enables low. That pair counts as one alternating event, and after it either input's next event is alternating.
- R8: An event from the same input as the previous event is a rate error. It latches steering: toward up (pump_up=1, pump_dn=0) for the reference, toward down for the feedback. Steering holds through events of the other input. A rate error from the other input reverses the direction.
- R9: Steering ends with the third consecutive alternating event after the last rate error. That event's phase-mode output (R5 to R7) applies at once.
- R10: pump_up and pump_dn are never high together.
- R11: locked rises with the 2*LOCK_PAIRS-th consecutive alternating event (8 by default) after reset or after the last rate error, provided steering is off.
- R12: locked falls on the same edge at which a rate error starts steering.
- R13: A synchronous active-high reset clears both enables, the lock flag and the steering state. The first event after reset is alternating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the faster input rate |
| rst | input | 1 | Synchronous active-high reset |
| dual_edge_cfg | input | 1 | Count both input transitions; captured during reset only |
| ref_in | input | 1 | Reference square wave, asynchronous |
| fb_in | input | 1 | Feedback pulse train, asynchronous |
| pump_up | output | 1 | Increase-rate drive enable |
| pump_dn | output | 1 | Decrease-rate drive enable |
| locked | output | 1 | No rate error over the qualifying run of events |

## Verification
An input change made at a falling edge is sampled at the next rising edge. The resulting pump_up, pump_dn and locked values are registered on the second rising edge after that, so there are three rising edges in all. One directed check samples the outputs after the first two of those edges and expects the old value, then samples again after the third and expects the new one. For every other stimulus, the bench waits four full cycles and then samples at a falling edge. By then each result is settled and cannot yet be disturbed by the next change. The expected values come from an event-level model in the bench, which is advanced once for each stimulus step.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  // Source of the most recent event
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_REF  = 2'd1,
    SRC_FB   = 2'd2
  } src_e;

  // Drive mode: proportional phase control or saturated steering
  typedef enum logic [1:0] {
    DRV_PHASE = 2'd0,
    DRV_UP    = 2'd1,
    DRV_DN    = 2'd2
  } steer_e;
endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic dual_en,
  input  logic sig_in,
  output logic ev
);
  // chain[0..STAGES-1]: synchronizer, chain[STAGES]: previous synced level
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], sig_in};
  end

  always_comb begin
    if (dual_en) ev = chain[STAGES-1] ^ chain[STAGES];
    else         ev = chain[STAGES-1] & ~chain[STAGES];
  end
endmodule

// File: rtl/pfd_steer_core.sv
module pfd_steer_core
  import pfd_pkg::*;
#(
  parameter int STEER_EXIT = 3,
  parameter int CNT_MAX    = 8,
  parameter int CNT_W      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_ref,
  input  logic             ev_fb,
  output logic             any_ev,
  output logic             freq_err,
  output steer_e           steer_nx,
  output steer_e           steer_q,
  output logic [CNT_W-1:0] run_nx
);
  src_e             last_q, last_nx;
  logic [CNT_W-1:0] run_q;

  assign any_ev   = ev_ref | ev_fb;
  assign freq_err = (ev_ref && !ev_fb && last_q == SRC_REF) ||
                    (ev_fb && !ev_ref && last_q == SRC_FB);

  always_comb begin
    if (ev_ref && ev_fb) last_nx = SRC_NONE;
    else if (ev_ref)     last_nx = SRC_REF;
    else if (ev_fb)      last_nx = SRC_FB;
    else                 last_nx = last_q;

    if (!any_ev)                         run_nx = run_q;
    else if (freq_err)                   run_nx = '0;
    else if (run_q == CNT_W'(CNT_MAX))   run_nx = run_q;
    else                                 run_nx = run_q + 1'b1;

    if (freq_err)                          steer_nx = ev_ref ? DRV_UP : DRV_DN;
    else if (any_ev && run_nx >= CNT_W'(STEER_EXIT)) steer_nx = DRV_PHASE;
    else                                   steer_nx = steer_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q  <= SRC_NONE;
      run_q   <= '0;
      steer_q <= DRV_PHASE;
    end else if (any_ev) begin
      last_q  <= last_nx;
      run_q   <= run_nx;
      steer_q <= steer_nx;
    end
  end
endmodule

// File: rtl/pfd_drive.sv
module pfd_drive
  import pfd_pkg::*;
#(
  parameter int LOCK_EVENTS = 8,
  parameter int CNT_W       = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             any_ev,
  input  logic             freq_err,
  input  logic             ev_ref,
  input  logic             ev_fb,
  input  steer_e           steer_nx,
  input  logic [CNT_W-1:0] run_nx,
  output logic             pump_up,
  output logic             pump_dn,
  output logic             locked
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pump_up <= 1'b0;
      pump_dn <= 1'b0;
      locked  <= 1'b0;
    end else if (any_ev) begin
      case (steer_nx)
        DRV_UP: begin
          pump_up <= 1'b1;
          pump_dn <= 1'b0;
        end
        DRV_DN: begin
          pump_up <= 1'b0;
          pump_dn <= 1'b1;
        end
        default: begin
          pump_up <= ev_ref & ~ev_fb;
          pump_dn <= ev_fb & ~ev_ref;
        end
      endcase
      locked <= !freq_err && (steer_nx == DRV_PHASE) &&
                (run_nx >= CNT_W'(LOCK_EVENTS));
    end
  end
endmodule

// File: rtl/phase_freq_steer.sv
module phase_freq_steer
  import pfd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_PAIRS  = 4,
  parameter int STEER_EXIT  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic dual_edge_cfg,
  input  logic ref_in,
  input  logic fb_in,
  output logic pump_up,
  output logic pump_dn,
  output logic locked
);
  localparam int LOCK_EVENTS = 2 * LOCK_PAIRS;
  localparam int CNT_MAX     = (LOCK_EVENTS > STEER_EXIT) ? LOCK_EVENTS : STEER_EXIT;
  localparam int CNT_W       = $clog2(CNT_MAX + 1);

  logic             dual_q;
  logic [1:0]       raw_in;
  logic [1:0]       ev_vec;
  logic             ev_ref, ev_fb, any_ev, freq_err;
  steer_e           steer_nx, steer_q;
  logic [CNT_W-1:0] run_nx;

  // Configuration is captured only while reset is held
  always_ff @(posedge clk) begin
    if (rst) dual_q <= dual_edge_cfg;
  end

  assign raw_in = {fb_in, ref_in};

  for (genvar g = 0; g < 2; g++) begin : g_in
    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .dual_en(dual_q),
      .sig_in (raw_in[g]),
      .ev     (ev_vec[g])
    );
  end

  assign ev_ref = ev_vec[0];
  assign ev_fb  = ev_vec[1];

  pfd_steer_core #(
    .STEER_EXIT(STEER_EXIT),
    .CNT_MAX   (CNT_MAX),
    .CNT_W     (CNT_W)
  ) u_core (
    .clk     (clk),
    .rst     (rst),
    .ev_ref  (ev_ref),
    .ev_fb   (ev_fb),
    .any_ev  (any_ev),
    .freq_err(freq_err),
    .steer_nx(steer_nx),
    .steer_q (steer_q),
    .run_nx  (run_nx)
  );

  pfd_drive #(
    .LOCK_EVENTS(LOCK_EVENTS),
    .CNT_W      (CNT_W)
  ) u_drive (
    .clk     (clk),
    .rst     (rst),
    .any_ev  (any_ev),
    .freq_err(freq_err),
    .ev_ref  (ev_ref),
    .ev_fb   (ev_fb),
    .steer_nx(steer_nx),
    .run_nx  (run_nx),
    .pump_up (pump_up),
    .pump_dn (pump_dn),
    .locked  (locked)
  );
endmodule

// File: rtl/pfd_steer_chk.sv
module pfd_steer_chk (
  input logic       clk,
  input logic       rst,
  input logic       ev_ref,
  input logic       ev_fb,
  input logic       freq_err,
  input logic [1:0] steer_mode,
  input logic       pump_up,
  input logic       pump_dn,
  input logic       locked
);
  p_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(pump_up && pump_dn));

  p_reset_r13: assert property (@(posedge clk)
    rst |=> (!pump_up && !pump_dn && !locked && steer_mode == 2'd0));

  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!ev_ref && !ev_fb) |=> ($stable(pump_up) && $stable(pump_dn) && $stable(locked)));

  p_steer_up_r8: assert property (@(posedge clk) disable iff (rst)
    (steer_mode == 2'd1) |-> (pump_up && !pump_dn));

  p_steer_dn_r8: assert property (@(posedge clk) disable iff (rst)
    (steer_mode == 2'd2) |-> (pump_dn && !pump_up));

  p_err_drop_r12: assert property (@(posedge clk) disable iff (rst)
    freq_err |=> (!locked && steer_mode != 2'd0));

  p_lock_phase_r11: assert property (@(posedge clk) disable iff (rst)
    locked |-> (steer_mode == 2'd0));
endmodule

bind phase_freq_steer pfd_steer_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .ev_ref    (ev_ref),
  .ev_fb     (ev_fb),
  .freq_err  (freq_err),
  .steer_mode(steer_q),
  .pump_up   (pump_up),
  .pump_dn   (pump_dn),
  .locked    (locked)
);

// File: tb/phase_freq_steer_test.sv
module phase_freq_steer_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dual_edge_cfg = 1'b0;
  logic ref_in = 1'b0;
  logic fb_in = 1'b0;
  logic pump_up, pump_dn, locked;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Event-level model derived from the requirements
  int m_last;   // 0 none, 1 reference, 2 feedback
  int m_run;
  int m_steer;  // 0 phase, 1 up, 2 down
  bit m_up, m_dn, m_lk, m_dual;

  always #5 clk = ~clk;

  phase_freq_steer uut (
    .clk          (clk),
    .rst          (rst),
    .dual_edge_cfg(dual_edge_cfg),
    .ref_in       (ref_in),
    .fb_in        (fb_in),
    .pump_up      (pump_up),
    .pump_dn      (pump_dn),
    .locked       (locked)
  );

  task automatic check(input bit eu, input bit ed, input bit el, input string req);
    n_chk++;
    if (pump_up !== eu || pump_dn !== ed || locked !== el) begin
      n_bad++;
      $display("FAIL %s: up/dn/lock got %b%b%b expected %b%b%b",
               req, pump_up, pump_dn, locked, eu, ed, el);
    end
  endtask

  task automatic model_event(input bit er, input bit ef);
    bit err;
    if (!er && !ef) return;
    err = (er && !ef && m_last == 1) || (ef && !er && m_last == 2);
    m_last = (er && ef) ? 0 : (er ? 1 : 2);
    if (err) begin
      m_run = 0;
      m_steer = er ? 1 : 2;
    end else begin
      if (m_run < 100) m_run++;
      if (m_run >= 3) m_steer = 0;
    end
    if (m_steer == 1)      begin m_up = 1; m_dn = 0; end
    else if (m_steer == 2) begin m_up = 0; m_dn = 1; end
    else begin m_up = er && !ef; m_dn = ef && !er; end
    m_lk = !err && m_steer == 0 && m_run >= 8;
  endtask

  // Called at a falling edge: set new levels, update model, wait, check
  task automatic step(input bit nr, input bit nf, input string req);
    bit er, ef;
    er = m_dual ? (nr != ref_in) : (nr && !ref_in);
    ef = m_dual ? (nf != fb_in)  : (nf && !fb_in);
    ref_in = nr;
    fb_in  = nf;
    model_event(er, ef);
    repeat (4) @(negedge clk);
    check(m_up, m_dn, m_lk, req);
  endtask

  task automatic do_reset(input bit dual);
    @(negedge clk);
    rst = 1'b1;
    dual_edge_cfg = dual;
    ref_in = 1'b0;
    fb_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_last = 0; m_run = 0; m_steer = 0;
    m_up = 0; m_dn = 0; m_lk = 0; m_dual = dual;
    @(negedge clk);
    check(1'b0, 1'b0, 1'b0, "R13 reset state");
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset(1'b0);

    // R1: latency, reference rise sampled at P1, outputs change at P3
    ref_in = 1'b1;
    model_event(1'b1, 1'b0);
    repeat (2) @(negedge clk);
    check(1'b0, 1'b0, 1'b0, "R1 before due edge");
    @(negedge clk);
    check(1'b1, 1'b0, 1'b0, "R1 at due edge / R5");
    repeat (2) @(negedge clk);

    step(1'b1, 1'b1, "R6 feedback event -> down");
    step(1'b0, 1'b1, "R2 falling reference ignored");
    step(1'b0, 1'b0, "R2 falling feedback ignored");
    // Alternating run: events 3..8, lock on the 8th (R11)
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 1'b0, "R5 reference event -> up");
      step(1'b0, 1'b0, "R2 fall");
      step(1'b0, 1'b1, "R11 alternating run / R6");
      step(1'b0, 1'b0, "R2 fall");
    end
    check(1'b0, 1'b1, 1'b1, "R11 locked after 8 alternating events");

    // R8/R12: two reference events in a row
    step(1'b1, 1'b0, "R5");
    step(1'b0, 1'b0, "R2");
    step(1'b1, 1'b0, "R12 rate error drops lock, R8 steer up");
    check(1'b1, 1'b0, 1'b0, "R8 steer up");
    step(1'b0, 1'b0, "R2");
    step(1'b0, 1'b1, "R8 steering holds through feedback");
    step(1'b0, 1'b0, "R2");
    step(1'b1, 1'b0, "R8 steering holds, second alternation");
    step(1'b0, 1'b0, "R2");
    step(1'b0, 1'b1, "R9 third alternation exits to phase down");
    check(1'b0, 1'b1, 1'b0, "R9 exit");
    step(1'b0, 1'b0, "R2");
    step(1'b0, 1'b1, "R8 feedback error steers down");
    check(1'b0, 1'b1, 1'b0, "R8 steer down");
    step(1'b0, 1'b0, "R2");
    step(1'b1, 1'b0, "R8 down holds");
    step(1'b1, 1'b1, "R8 down holds");
    step(1'b0, 1'b0, "R2");
    step(1'b1, 1'b1, "R7 simultaneous events");
    check(1'b0, 1'b0, 1'b0, "R7 both low after exit");

    // R3: dual-edge mode, rise then fall of reference is a rate error
    do_reset(1'b1);
    step(1'b1, 1'b0, "R3 rise");
    step(1'b0, 1'b0, "R3 fall counts, steer up");
    check(1'b1, 1'b0, 1'b0, "R3 falling edge is event");

    // R4: configuration change after reset has no effect
    do_reset(1'b0);
    dual_edge_cfg = 1'b1;
    step(1'b1, 1'b0, "R4 rise");
    step(1'b0, 1'b0, "R4 fall still ignored");
    check(1'b1, 1'b0, 1'b0, "R4 single-edge kept");
    dual_edge_cfg = 1'b0;

    // Random runs in both modes (R5..R11, R10)
    for (int mode = 0; mode < 2; mode++) begin
      do_reset(mode[0]);
      for (int k = 0; k < 400; k++) begin
        int pick;
        bit nr, nf;
        pick = int'($urandom_range(0, 9));
        nr = ref_in;
        nf = fb_in;
        if (pick < 4)      nr = ~ref_in;
        else if (pick < 8) nf = ~fb_in;
        else begin nr = ~ref_in; nf = ~fb_in; end
        step(nr, nf, "R10 random pattern");
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule